// File: doc/BRIEF.md
# Pipelined Floating-Point Adder/Subtractor

This block adds or subtracts two floating-point operands in a four-segment pipeline. Each operand has a 1-bit sign, an 8-bit biased exponent and a 24-bit mantissa. The mantissa carries an explicit leading one. An operation bit selects addition or subtraction. A new operand pair can enter on every clock. The normalized result, together with a valid flag, leaves the block four clocks after it entered.

The work is split across four register-separated segments:

1. The two exponents are subtracted.
2. The larger exponent becomes the tentative result exponent, and the smaller operand's mantissa is shifted right by the difference. Bits shifted out are discarded.
3. The aligned mantissas are added or subtracted.
4. The result is normalized and its exponent is adjusted to match.

Rounding, denormals, infinities, NaN and exception flags are not modelled. Exponent arithmetic wraps modulo 256.

Top module: `fp_addsub_pipe`

## Requirements
- R1: An operand pair sampled with `in_valid` high on a rising edge produces `out_valid` high, with its result, after exactly four rising edges (counting the capturing edge). A cycle with `in_valid` low produces `out_valid` low four edges later. Back-to-back pairs are accepted on every clock.
- R2: When `op_sub` is 1, the result is A minus B, computed as A plus B with B's sign inverted. When `op_sub` is 0, the result is A plus B. Sign bit 1 means negative.
- R3: The result exponent starts as the larger input exponent. The smaller operand's mantissa is shifted right by the exponent difference, and the shifted-out bits are truncated.
- R4: When the exponent difference is 24 or more, the smaller operand contributes zero, and the result equals the larger operand.
- R5: When the mantissa sum carries out of bit 23, the result is shifted right by one and the exponent is incremented by one.
- R6: When the mantissa result has leading zeros, it is shifted left until bit 23 is 1, and the exponent is decreased by the shift count. Every non-zero valid result has bit 23 of `out_man` set.
- R7: A zero mantissa result is reported with sign 0, exponent 0 and mantissa 0.
- R8: When the signs effectively differ and the smaller-exponent operand's aligned mantissa is the larger one (possible only with equal exponents), the magnitudes are swapped and the result takes that operand's effective sign.
- R9: While `rst_n` is low, and afterwards until data arrives, `out_valid`, `out_sign`, `out_exp` and `out_man` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand pair present this cycle |
| op_sub | input | 1 | 1 = subtract B from A, 0 = add |
| a_sign | input | 1 | Sign of A |
| a_exp | input | 8 | Biased exponent of A |
| a_man | input | 24 | Mantissa of A, explicit leading one |
| b_sign | input | 1 | Sign of B |
| b_exp | input | 8 | Biased exponent of B |
| b_man | input | 24 | Mantissa of B, explicit leading one |
| out_valid | output | 1 | Result present this cycle |
| out_sign | output | 1 | Result sign |
| out_exp | output | 8 | Result exponent |
| out_man | output | 24 | Normalized result mantissa |

## Verification
A wrong exponent difference or a wrong choice of larger operand in the early segments shows up at the ports as a mis-scaled mantissa or a wrong sign, exactly four clocks after the pair entered. A fault in the normalization count shows up in the same cycle as an unnormalized mantissa or an exponent off by the miscount. The reference model predicts every output cycle, including bubbles. A dropped or duplicated valid flag is therefore caught on the first cycle it occurs.

// File: rtl/fp_addsub_pipe.sv
module fp_addsub_pipe #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             op_sub,
  input  logic             a_sign,
  input  logic [EXP_W-1:0] a_exp,
  input  logic [MAN_W-1:0] a_man,
  input  logic             b_sign,
  input  logic [EXP_W-1:0] b_exp,
  input  logic [MAN_W-1:0] b_man,
  output logic             out_valid,
  output logic             out_sign,
  output logic [EXP_W-1:0] out_exp,
  output logic [MAN_W-1:0] out_man
);
  localparam int LZ_W = $clog2(MAN_W + 1);

  // segment 1: exponent compare
  logic             s1_v, s1_as, s1_bs;
  logic [EXP_W-1:0] s1_ae, s1_be;
  logic [MAN_W-1:0] s1_am, s1_bm;
  logic [EXP_W:0]   s1_diff;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1_v <= 1'b0; s1_as <= 1'b0; s1_bs <= 1'b0;
      s1_ae <= '0; s1_be <= '0; s1_am <= '0; s1_bm <= '0; s1_diff <= '0;
    end else begin
      s1_v    <= in_valid;
      s1_as   <= a_sign;
      s1_bs   <= b_sign ^ op_sub;
      s1_ae   <= a_exp;
      s1_be   <= b_exp;
      s1_am   <= a_man;
      s1_bm   <= b_man;
      s1_diff <= {1'b0, a_exp} - {1'b0, b_exp};
    end

  // segment 2: alignment
  logic             a_ge;
  logic [EXP_W-1:0] shamt;
  logic [MAN_W-1:0] small_m;
  logic             far;
  assign a_ge    = ~s1_diff[EXP_W];
  assign shamt   = a_ge ? s1_diff[EXP_W-1:0] : (~s1_diff[EXP_W-1:0] + 1'b1);
  assign far     = (int'(shamt) >= MAN_W);
  assign small_m = far ? '0 : ((a_ge ? s1_bm : s1_am) >> shamt);

  logic             s2_v, s2_bs, s2_ss;
  logic [EXP_W-1:0] s2_e;
  logic [MAN_W-1:0] s2_bm, s2_sm;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s2_v <= 1'b0; s2_bs <= 1'b0; s2_ss <= 1'b0;
      s2_e <= '0; s2_bm <= '0; s2_sm <= '0;
    end else begin
      s2_v  <= s1_v;
      s2_e  <= a_ge ? s1_ae : s1_be;
      s2_bs <= a_ge ? s1_as : s1_bs;
      s2_bm <= a_ge ? s1_am : s1_bm;
      s2_ss <= a_ge ? s1_bs : s1_as;
      s2_sm <= small_m;
    end

  // segment 3: add / subtract
  logic             eff_sub, big_ge;
  logic [MAN_W:0]   sum;
  logic             sum_s;
  assign eff_sub = s2_bs ^ s2_ss;
  assign big_ge  = (s2_bm >= s2_sm);
  assign sum     = !eff_sub ? ({1'b0, s2_bm} + {1'b0, s2_sm}) :
                   big_ge   ? ({1'b0, s2_bm} - {1'b0, s2_sm}) :
                              ({1'b0, s2_sm} - {1'b0, s2_bm});
  assign sum_s   = (eff_sub && !big_ge) ? s2_ss : s2_bs;

  logic             s3_v, s3_s, s3_sub;
  logic [EXP_W-1:0] s3_e;
  logic [MAN_W:0]   s3_sum;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s3_v <= 1'b0; s3_s <= 1'b0; s3_sub <= 1'b0; s3_e <= '0; s3_sum <= '0;
    end else begin
      s3_v   <= s2_v;
      s3_s   <= sum_s;
      s3_sub <= eff_sub;
      s3_e   <= s2_e;
      s3_sum <= sum;
    end

  // segment 4: normalize
  logic [LZ_W-1:0]  lz;
  logic             found;
  always_comb begin
    lz = '0;
    found = 1'b0;
    for (int i = MAN_W - 1; i >= 0; i--) begin
      if (!found) begin
        if (s3_sum[i]) found = 1'b1;
        else           lz = lz + 1'b1;
      end
    end
  end

  logic             n_s;
  logic [EXP_W-1:0] n_e;
  logic [MAN_W-1:0] n_m;
  always_comb begin
    if (s3_sum[MAN_W]) begin
      n_s = s3_s;
      n_e = s3_e + 1'b1;
      n_m = s3_sum[MAN_W:1];
    end else if (!found) begin
      n_s = 1'b0;
      n_e = '0;
      n_m = '0;
    end else begin
      n_s = s3_s;
      n_e = s3_e - EXP_W'(lz);
      n_m = s3_sum[MAN_W-1:0] << lz;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      out_valid <= 1'b0; out_sign <= 1'b0; out_exp <= '0; out_man <= '0;
    end else begin
      out_valid <= s3_v;
      out_sign  <= n_s;
      out_exp   <= n_e;
      out_man   <= n_m;
    end

  // checks
  logic [2:0] age;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          age <= '0;
    else if (age != 3'd4) age <= age + 3'd1;

  p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 3'd4) |-> (out_valid == $past(in_valid, 4)));

  p_far_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_v && far) |=> (s2_sm == '0));

  p_carry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (s3_v && s3_sum[MAN_W]) |=>
      (out_valid && out_man == $past(s3_sum[MAN_W:1]) && out_exp == $past(s3_e) + 1'b1));

  p_no_carry_sub_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (s3_v && s3_sub) |-> !s3_sum[MAN_W]);

  p_normalized_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_man != '0) |-> out_man[MAN_W-1]);

  p_zero_form_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_man == '0) |-> (out_exp == '0 && !out_sign));
endmodule

// File: tb/test_fp_addsub_pipe.sv
`timescale 1ns/1ps
module test_fp_addsub_pipe;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, op_sub = 1'b0;
  logic        a_sign = 1'b0, b_sign = 1'b0;
  logic [7:0]  a_exp = '0, b_exp = '0;
  logic [23:0] a_man = '0, b_man = '0;
  logic        out_valid, out_sign;
  logic [7:0]  out_exp;
  logic [23:0] out_man;

  always #2 clk = ~clk;

  fp_addsub_pipe i_fp_addsub_pipe (
    .clk, .rst_n, .in_valid, .op_sub, .a_sign, .a_exp, .a_man,
    .b_sign, .b_exp, .b_man, .out_valid, .out_sign, .out_exp, .out_man);

  int compared = 0, mismatched = 0;
  bit done = 0;
  logic        hv [4];
  logic [32:0] hr [4];
  string       ht [4];

  function automatic logic [32:0] model(bit as, int ae, longint am, bit bs, int be, longint bm, bit sub);
    bit s, bigs, smls;
    int e, d;
    longint bigm, smlm, r;
    bs = bs ^ sub;
    if (ae >= be) begin e = ae; d = ae - be; bigs = as; bigm = am; smls = bs; smlm = bm; end
    else          begin e = be; d = be - ae; bigs = bs; bigm = bm; smls = as; smlm = am; end
    smlm = (d >= 24) ? 0 : (smlm >> d);
    if (bigs == smls)     begin r = bigm + smlm; s = bigs; end
    else if (bigm >= smlm) begin r = bigm - smlm; s = bigs; end
    else                   begin r = smlm - bigm; s = smls; end
    if (r == 0) return '0;
    while (r >= 64'd16777216) begin r = r >> 1; e = e + 1; end
    while (r <  64'd8388608)  begin r = r << 1; e = e - 1; end
    return {s, 8'(e), 24'(r)};
  endfunction

  task automatic check(string tag, logic [32:0] act, logic [32:0] exp_v);
    compared++;
    if (act !== exp_v) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp_v);
    end
  endtask

  task automatic cyc(bit v, bit sub, bit as, logic [7:0] ae, logic [23:0] am,
                     bit bs, logic [7:0] be, logic [23:0] bm, string tag);
    in_valid = v; op_sub = sub;
    a_sign = as; a_exp = ae; a_man = am;
    b_sign = bs; b_exp = be; b_man = bm;
    @(posedge clk);
    for (int i = 3; i > 0; i--) begin hv[i] = hv[i-1]; hr[i] = hr[i-1]; ht[i] = ht[i-1]; end
    hv[0] = v;
    hr[0] = model(as, int'(ae), longint'(am), bs, int'(be), longint'(bm), sub);
    ht[0] = tag;
    @(negedge clk);
    check({ht[3], " valid"}, {32'b0, out_valid}, {32'b0, hv[3]});
    if (hv[3]) check(ht[3], {out_sign, out_exp, out_man}, hr[3]);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    #400000;
    compared++; mismatched++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 4; i++) begin hv[i] = 0; hr[i] = '0; ht[i] = "R1 bubble"; end
    repeat (3) @(negedge clk);
    check("R9 reset outputs", {out_valid, out_sign, out_exp, out_man}, 34'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 after reset", {out_valid, out_sign, out_exp, out_man}, 34'b0);
    cyc(1, 0, 0, 8'd127, 24'h800000, 0, 8'd127, 24'h800000, "R5 carry 1+1");
    cyc(1, 0, 0, 8'd130, 24'hC00000, 0, 8'd127, 24'hA00007, "R3 align truncate");
    cyc(1, 0, 0, 8'd150, 24'h923456, 0, 8'd126, 24'hFFFFFF, "R4 diff 24");
    cyc(1, 1, 0, 8'd200, 24'h800001, 1, 8'd10, 24'h800000, "R4 diff large");
    cyc(0, 0, 0, 8'd0, 24'h0, 0, 8'd0, 24'h0, "R1 bubble");
    cyc(1, 1, 0, 8'd127, 24'h800001, 0, 8'd127, 24'h800000, "R6 cancel");
    cyc(1, 1, 0, 8'd100, 24'hABCDEF, 0, 8'd100, 24'hABCDEF, "R7 zero");
    cyc(1, 1, 0, 8'd90, 24'h900000, 0, 8'd90, 24'hF00000, "R8 swap sign");
    cyc(1, 1, 1, 8'd90, 24'h900000, 1, 8'd90, 24'hF00000, "R8 swap neg");
    cyc(1, 1, 0, 8'd64, 24'h800000, 1, 8'd64, 24'h800000, "R2 sub neg b");
    cyc(1, 0, 1, 8'd64, 24'hC00000, 0, 8'd63, 24'hC00000, "R2 add mixed");
    cyc(1, 1, 0, 8'd128, 24'h800000, 0, 8'd127, 24'hFFFFFF, "R6 deep shift");
    cyc(0, 1, 1, 8'd50, 24'h812345, 0, 8'd40, 24'h800000, "R1 bubble ignored");
    cyc(0, 0, 0, 8'd0, 24'h0, 0, 8'd0, 24'h0, "R1 bubble");
    for (int n = 0; n < 3000; n++) begin
      bit v;
      v = ($urandom_range(0, 7) != 0);
      cyc(v, 1'($urandom), 1'($urandom), 8'($urandom_range(40, 200)), 24'($urandom) | 24'h800000,
          1'($urandom), 8'($urandom_range(40, 200)), 24'($urandom) | 24'h800000, "R1 stream");
    end
    for (int n = 0; n < 500; n++)
      cyc(1, 1'($urandom), 1'($urandom), 8'($urandom_range(100, 103)), 24'h800000 | 24'($urandom_range(0, 15)),
          1'($urandom), 8'($urandom_range(100, 103)), 24'h800000 | 24'($urandom_range(0, 15)), "R6 near cancel");
    for (int n = 0; n < 4; n++) cyc(0, 0, 0, 8'd0, 24'h0, 0, 8'd0, 24'h0, "R1 drain");
    finish_run();
  end
endmodule